// File: doc/BRIEF.md
# Read-Port Access Decoder with Mailboxes

This block is the control decoder that sits on the read side of a 36-bit clocked FIFO. On every rising edge of the port clock it looks at an active-low select, a direction line, an enable and a two-bit size code. From these it picks one of three actions. It can issue a FIFO read strobe, load the outbound mailbox from the bus, or read the inbound mailbox and release its full indication. It also drives the output enable and the output-source select for the 36-bit data bus.

The size code `2'b11` turns an ordinary port access into a mailbox access. This holds in both directions. Any other size code means the access goes to the FIFO.

Each mailbox has an active-low full flag, where low means data is waiting. The inbound mailbox is loaded by the opposite port. The outbound mailbox is acknowledged, and so emptied, by the opposite port. The FIFO memory, flag synchronization and width matching are not part of this block.

Top module: `portb_access_ctrl`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears both mailbox registers to zero and sets both `mbx1_full_n` and `mbx2_full_n` high.
- R2: While `sel_n` is high, `bus_oe` is low and `fifo_rd` is low, and no mailbox register or flag changes at the edge because of port activity.
- R3: While `wr_dir` is high (write direction), `bus_oe` is low whatever the other inputs are.
- R4: With `sel_n` low and `wr_dir` low, `bus_oe` is high. `bus_out` then carries `fifo_q` when `size` is not `2'b11`, and carries the inbound mailbox (mailbox 1) when `size` is `2'b11`. `bus_src_mbx` is high exactly in the second case.
- R5: `fifo_rd` is high in the same cycle as `sel_n` low, `wr_dir` low, `en` high, `size` not `2'b11` and `fifo_not_empty` high. It is low otherwise.
- R6: A FIFO read attempted while `fifo_not_empty` is low produces no `fifo_rd` strobe.
- R7: A rising edge with `sel_n` low, `wr_dir` high, `en` high, `size` `2'b11` and `mbx2_full_n` high loads `bus_in` into the outbound mailbox (`mbx2_q`). `mbx2_full_n` is low from the next cycle.
- R8: While `mbx2_full_n` is low, a further mailbox-2 write is ignored: `mbx2_q` keeps its value.
- R9: A rising edge with `mbx2_ack` high and no accepted mailbox-2 write sets `mbx2_full_n` high.
- R10: A rising edge with `mbx1_ld` high and `mbx1_full_n` high loads `mbx1_din` into mailbox 1 and drives `mbx1_full_n` low. When `mbx1_full_n` is already low, the load is ignored.
- R11: A rising edge with `sel_n` low, `wr_dir` low, `en` high and `size` `2'b11`, and with no accepted mailbox-1 load on that edge, sets `mbx1_full_n` high. The same access with `en` low leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low port select |
| wr_dir | input | 1 | Direction: 1 = write into block, 0 = read |
| en | input | 1 | Access enable |
| size | input | 2 | Size code; `2'b11` selects mailbox access |
| fifo_not_empty | input | 1 | High when the FIFO holds readable data |
| fifo_q | input | 36 | FIFO output register contents |
| bus_in | input | 36 | Data bus input, source of mailbox-2 writes |
| bus_out | output | 36 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable (low = high impedance) |
| bus_src_mbx | output | 1 | Output source: 1 = mailbox 1, 0 = FIFO |
| fifo_rd | output | 1 | FIFO read strobe |
| mbx1_ld | input | 1 | Opposite port loads mailbox 1 |
| mbx1_din | input | 36 | Data for mailbox-1 load |
| mbx1_full_n | output | 1 | Mailbox-1 full flag, active low |
| mbx2_ack | input | 1 | Opposite port has read mailbox 2 |
| mbx2_q | output | 36 | Mailbox-2 contents toward the opposite port |
| mbx2_full_n | output | 1 | Mailbox-2 full flag, active low |

## Verification
The bus enable, the source select, the bus value and the read strobe are combinational. They are due in the same cycle as the inputs that cause them, so the bench drives on the falling edge and samples one time unit later. Mailbox contents and both full flags are due one rising edge after the causing access. The bench therefore updates its own mailbox model at that edge and compares shortly after it. The sweep covers every mix of select, direction, enable, size, empty state, load and acknowledge. This lets the set/clear ordering at each edge be compared against the model.

// File: rtl/portb_pkg.sv
package portb_pkg;

   typedef enum logic [1:0] {
      ACT_NONE    = 2'd0,
      ACT_FIFO_RD = 2'd1,
      ACT_MBX2_WR = 2'd2,
      ACT_MBX1_RD = 2'd3
   } port_act_e;

   localparam int unsigned SIZE_W   = 2;
   localparam logic [SIZE_W-1:0] SIZE_MBX = 2'b11;

endpackage

// File: rtl/portb_decode.sv
module portb_decode
   import portb_pkg::*;
(
   input  logic              sel_n,
   input  logic              wr_dir,
   input  logic              en,
   input  logic [SIZE_W-1:0] size,
   output port_act_e         act,
   output logic              drive_en,
   output logic              src_mbx
);

   logic mbx_sz;

   always_comb begin
      mbx_sz   = (size == SIZE_MBX);
      drive_en = !sel_n && !wr_dir;
      src_mbx  = drive_en && mbx_sz;
      act      = ACT_NONE;
      if (!sel_n && en) begin
         if (wr_dir) begin
            if (mbx_sz) act = ACT_MBX2_WR;
         end else begin
            act = mbx_sz ? ACT_MBX1_RD : ACT_FIFO_RD;
         end
      end
   end

endmodule

// File: rtl/portb_mailbox.sv
module portb_mailbox #(
   parameter int unsigned W = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         put,
   input  logic [W-1:0] put_data,
   input  logic         take,
   output logic [W-1:0] data,
   output logic         full_n
);

   logic accept;

   assign accept = put && full_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data   <= '0;
         full_n <= 1'b1;
      end else if (accept) begin
         data   <= put_data;
         full_n <= 1'b0;
      end else if (take) begin
         full_n <= 1'b1;
      end
   end

endmodule

// File: rtl/portb_bus_drive.sv
module portb_bus_drive #(
   parameter int unsigned W         = 36,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic         drive_en,
   input  logic         src_mbx,
   input  logic [W-1:0] fifo_q,
   input  logic [W-1:0] mbx_q,
   output logic [W-1:0] bus_out
);

   logic [W-1:0] sel_val;

   assign sel_val = src_mbx ? mbx_q : fifo_q;

   generate
      if (IDLE_ZERO) begin : g_idle_zero
         assign bus_out = drive_en ? sel_val : '0;
      end else begin : g_idle_pass
         assign bus_out = sel_val;
      end
   endgenerate

endmodule

// File: rtl/portb_access_ctrl.sv
module portb_access_ctrl
   import portb_pkg::*;
#(
   parameter int unsigned DATA_W    = 36,
   parameter bit          IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              wr_dir,
   input  logic              en,
   input  logic [1:0]        size,
   input  logic              fifo_not_empty,
   input  logic [DATA_W-1:0] fifo_q,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              bus_src_mbx,
   output logic              fifo_rd,
   input  logic              mbx1_ld,
   input  logic [DATA_W-1:0] mbx1_din,
   output logic              mbx1_full_n,
   input  logic              mbx2_ack,
   output logic [DATA_W-1:0] mbx2_q,
   output logic              mbx2_full_n
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("portb_access_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   port_act_e         act;
   logic              drive_en;
   logic              src_mbx;
   logic [DATA_W-1:0] mbx1_q;

   portb_decode u_decode (
      .sel_n    (sel_n),
      .wr_dir   (wr_dir),
      .en       (en),
      .size     (size),
      .act      (act),
      .drive_en (drive_en),
      .src_mbx  (src_mbx)
   );

   assign fifo_rd     = (act == ACT_FIFO_RD) && fifo_not_empty;
   assign bus_oe      = drive_en;
   assign bus_src_mbx = src_mbx;

   portb_mailbox #(.W(DATA_W)) u_mbx1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .put      (mbx1_ld),
      .put_data (mbx1_din),
      .take     (act == ACT_MBX1_RD),
      .data     (mbx1_q),
      .full_n   (mbx1_full_n)
   );

   portb_mailbox #(.W(DATA_W)) u_mbx2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .put      (act == ACT_MBX2_WR),
      .put_data (bus_in),
      .take     (mbx2_ack),
      .data     (mbx2_q),
      .full_n   (mbx2_full_n)
   );

   portb_bus_drive #(.W(DATA_W), .IDLE_ZERO(IDLE_ZERO)) u_drive (
      .drive_en (drive_en),
      .src_mbx  (src_mbx),
      .fifo_q   (fifo_q),
      .mbx_q    (mbx1_q),
      .bus_out  (bus_out)
   );

endmodule

module portb_access_ctrl_chk #(
   parameter int unsigned DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              wr_dir,
   input logic              en,
   input logic [1:0]        size,
   input logic              fifo_not_empty,
   input logic [DATA_W-1:0] bus_in,
   input logic              bus_oe,
   input logic              fifo_rd,
   input logic              mbx1_ld,
   input logic              mbx1_full_n,
   input logic              mbx2_ack,
   input logic [DATA_W-1:0] mbx2_q,
   input logic              mbx2_full_n
);

   p_idle_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> (!bus_oe && !fifo_rd));

   p_wr_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |-> !bus_oe);

   p_no_rd_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_not_empty |-> !fifo_rd);

   p_mbx2_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && wr_dir && en && size == 2'b11 && mbx2_full_n)
      |=> (!mbx2_full_n && mbx2_q == $past(bus_in)));

   p_mbx2_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mbx2_full_n && !mbx2_ack) |=> (!mbx2_full_n && $stable(mbx2_q)));

   p_mbx1_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !wr_dir && en && size == 2'b11 && !mbx1_full_n) |=> mbx1_full_n);

   p_mbx1_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx1_ld && mbx1_full_n) |=> !mbx1_full_n);

endmodule

bind portb_access_ctrl portb_access_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sel_n          (sel_n),
   .wr_dir         (wr_dir),
   .en             (en),
   .size           (size),
   .fifo_not_empty (fifo_not_empty),
   .bus_in         (bus_in),
   .bus_oe         (bus_oe),
   .fifo_rd        (fifo_rd),
   .mbx1_ld        (mbx1_ld),
   .mbx1_full_n    (mbx1_full_n),
   .mbx2_ack       (mbx2_ack),
   .mbx2_q         (mbx2_q),
   .mbx2_full_n    (mbx2_full_n)
);

// File: tb/portb_access_ctrl_tb.sv
module portb_access_ctrl_tb;

   localparam int unsigned W        = 36;
   localparam time         CLK_HALF = 5;
   localparam int          WATCHDOG = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel_n = 1'b1, wr_dir = 1'b0, en = 1'b0;
   logic [1:0]   size = 2'b00;
   logic         fifo_not_empty = 1'b0;
   logic [W-1:0] fifo_q = '0, bus_in = '0, mbx1_din = '0;
   logic         mbx1_ld = 1'b0, mbx2_ack = 1'b0;
   logic [W-1:0] bus_out, mbx2_q;
   logic         bus_oe, bus_src_mbx, fifo_rd, mbx1_full_n, mbx2_full_n;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #CLK_HALF clk = ~clk;

   portb_access_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_dir(wr_dir), .en(en),
      .size(size), .fifo_not_empty(fifo_not_empty), .fifo_q(fifo_q),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .bus_src_mbx(bus_src_mbx), .fifo_rd(fifo_rd), .mbx1_ld(mbx1_ld),
      .mbx1_din(mbx1_din), .mbx1_full_n(mbx1_full_n), .mbx2_ack(mbx2_ack),
      .mbx2_q(mbx2_q), .mbx2_full_n(mbx2_full_n)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // bench-side mailbox model
   logic [W-1:0] m1d, m2d;
   logic         m1f, m2f;

   initial begin
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); #1;
      m1d = '0; m2d = '0; m1f = 1'b1; m2f = 1'b1;
      chk("R1 mbx1_full_n", W'(mbx1_full_n), W'(1));
      chk("R1 mbx2_full_n", W'(mbx2_full_n), W'(1));
      chk("R1 mbx2_q", mbx2_q, '0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 512; i++) begin
         logic mb, rdm1, wrm2, exp_oe, exp_rd;
         @(negedge clk);
         sel_n          = i[0];
         wr_dir         = i[1];
         en             = i[2];
         size           = i[4:3];
         fifo_not_empty = i[5];
         mbx1_ld        = i[6];
         mbx2_ack       = i[7];
         fifo_q   = {4'hA, 32'(i * 32'h01010101)};
         bus_in   = {4'h5, 32'(i * 32'h00370101 + 7)};
         mbx1_din = {4'hC, 32'(i * 32'h10003 + 1)};
         #1;
         mb     = (size == 2'b11);
         exp_oe = !sel_n && !wr_dir;
         exp_rd = !sel_n && !wr_dir && en && !mb && fifo_not_empty;
         if (sel_n) chk("R2 bus_oe", W'(bus_oe), W'(0));
         else if (wr_dir) chk("R3 bus_oe", W'(bus_oe), W'(0));
         else chk("R4 bus_oe", W'(bus_oe), W'(1));
         if (exp_oe) begin
            chk("R4 bus_src_mbx", W'(bus_src_mbx), W'(mb));
            chk("R4 bus_out", bus_out, mb ? m1d : fifo_q);
         end
         if (!fifo_not_empty) chk("R6 fifo_rd", W'(fifo_rd), W'(0));
         else chk("R5 fifo_rd", W'(fifo_rd), W'(exp_rd));
         rdm1 = !sel_n && !wr_dir && en && mb;
         wrm2 = !sel_n && wr_dir && en && mb;
         @(posedge clk); #1;
         if (mbx1_ld && m1f) begin m1d = mbx1_din; m1f = 1'b0; end
         else if (rdm1) m1f = 1'b1;
         if (wrm2 && m2f) begin m2d = bus_in; m2f = 1'b0; end
         else if (mbx2_ack) m2f = 1'b1;
         chk(mbx1_ld ? "R10 mbx1_full_n" : (rdm1 ? "R11 mbx1_full_n" : "R2 mbx1_full_n"),
             W'(mbx1_full_n), W'(m1f));
         chk(wrm2 ? "R7 mbx2_full_n" : (mbx2_ack ? "R9 mbx2_full_n" : "R2 mbx2_full_n"),
             W'(mbx2_full_n), W'(m2f));
         chk(wrm2 ? "R8 mbx2_q" : "R7 mbx2_q", mbx2_q, m2d);
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule